// File: doc/BRIEF.md
# Variable-Precision Multiply-Accumulate Slice

This block is a pipelined fixed-point multiply-accumulate slice for DSP datapaths. A mode input chooses between two arrangements. In the narrow arrangement, two signed 18-bit by 18-bit products are formed and then summed. In the wide arrangement, a single signed 27-bit by 27-bit product is formed. Each multiplier has an optional pre-adder on its first operand. Its second operand can come from the data port or from a small private coefficient bank. A 64-bit cascade input from a neighbouring slice is added to the product sum.

The product sum then goes to a 64-bit accumulator, which has a feedback register, a per-sample enable and a per-sample clear. A registered output multiplexer presents either the accumulated value or the raw product sum. The accumulated value is also driven onto a 64-bit cascade output for the next slice. Every result leaves the slice exactly three clock edges after its operands enter, and a valid flag travels with it. Slices can be chained through their cascade ports to build wider or complex multipliers.

Top module: `vp_mac_slice`

## Requirements
- R1: With `mode_wide`=0, the product sum is sext(a0[17:0])*sext(b0[17:0]) plus the second product sext(a1[17:0])*sext(b1[17:0]). The second product is negated first when `sub_p1`=1.
- R2: An operand of 9 bits sign-extended into the 18-bit field gives the same result as a true signed 9x9 multiply.
- R3: With `mode_wide`=1, the product sum is the signed 27x27 product a0*b0. The path-1 inputs and `sub_p1` have no effect.
- R4: When pre_en[k]=1, the first operand of path k is a±d, with subtraction when pre_sub[k]=1. In narrow mode a and d are taken as 18-bit signed values. In wide mode they are taken as 25-bit signed values (bits 24:0), which gives a 26-bit sum. When pre_en[k]=0, the first operand is a alone: 18 bits in narrow mode, 27 bits in wide mode.
- R5: When coef_sel[k]=1, path k takes its second operand from entry coef_idxk of bank k instead of from bk. In narrow mode only bits 17:0 of the entry are used. A write (`coef_we`, bank `coef_wsel`, `coef_waddr`, `coef_wdata`) is seen by samples presented on the cycle after the write. A sample presented on the same cycle as the write reads the old contents. All banks reset to zero.
- R6: `cascade_in` is added to the product sum. `cascade_out` carries the registered accumulator value.
- R7: When `acc_en`=1, the new sum is added to the previous accumulator value, wrapping modulo 2^64. When `acc_en`=0, the feedback term is zero.
- R8: When `acc_clr`=1 and `acc_en`=1, the accumulator loads the current sum instead of adding to it.
- R9: A sample presented with `in_valid`=1 before clock edge N is reflected in the outputs after edge N+2, with `result_valid`=1. Cycles without a valid sample leave `result` and `cascade_out` unchanged.
- R10: When `out_sel`=0, `result` is the new accumulator value. When `out_sel`=1, `result` is the product sum including the cascade term, and the accumulator is still updated.
- R11: After reset, `result`, `cascade_out` and `result_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wide | input | 1 | 0 selects the two narrow products, 1 selects the single wide product |
| in_valid | input | 1 | Sample present |
| a0 | input | 27 | Path 0 first operand |
| d0 | input | 27 | Path 0 pre-adder operand |
| b0 | input | 27 | Path 0 second operand |
| a1 | input | 27 | Path 1 first operand |
| d1 | input | 27 | Path 1 pre-adder operand |
| b1 | input | 27 | Path 1 second operand |
| pre_en | input | 2 | Per-path pre-adder enable |
| pre_sub | input | 2 | Per-path pre-adder subtract |
| coef_sel | input | 2 | Per-path second operand from the coefficient bank |
| coef_idx0 | input | 3 | Bank entry for path 0 |
| coef_idx1 | input | 3 | Bank entry for path 1 |
| sub_p1 | input | 1 | Negate the path 1 product |
| acc_en | input | 1 | Add the previous accumulator value |
| acc_clr | input | 1 | Load the sum and drop the previous value |
| out_sel | input | 1 | 0 accumulator, 1 raw product sum |
| cascade_in | input | 64 | Sum from the neighbouring slice |
| coef_we | input | 1 | Coefficient write strobe |
| coef_wsel | input | 1 | Bank written (0 path 0, 1 path 1) |
| coef_waddr | input | 3 | Entry written |
| coef_wdata | input | 27 | Coefficient value |
| result | output | 64 | Registered output multiplexer |
| result_valid | output | 1 | Result carries a new sample |
| cascade_out | output | 64 | Accumulator value for the next slice |

## Verification
Each sample's result, cascade value and valid flag are due at the sampling point after the third rising edge that follows the cycle in which the sample was driven. Idle cycles are due at the same offset, and there the previous values must still be present. The bench drives inputs just after a falling edge and computes the expected entry for that cycle behaviourally. It places the entry in a queue that was seeded with two reset-state entries, so the head of the queue is compared with the ports at each falling edge. A coefficient write is applied to the bench's bank copy only after that cycle's expectation has been formed, which models the one-cycle visibility of a write.

// File: rtl/vp_mac_pkg.sv
package vp_mac_pkg;

   typedef enum logic {
      MODE_DUAL = 1'b0,
      MODE_WIDE = 1'b1
   } mac_mode_e;

   typedef enum logic {
      OSEL_ACC = 1'b0,
      OSEL_SUM = 1'b1
   } out_sel_e;

   localparam int NUM_PATHS = 2;

endpackage

// File: rtl/vp_coef_bank.sv
module vp_coef_bank #(
   parameter int COEF_W = 27,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [COEF_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [COEF_W-1:0] rdata
);

   logic [COEF_W-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_depth_bad
      initial $fatal(1, "vp_coef_bank: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // read sees the contents before any write on the same edge
   assign rdata = mem[raddr];

   AST_COEF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata)); // R5

endmodule

// File: rtl/vp_operand_path.sv
module vp_operand_path #(
   parameter int NARROW_W = 18,
   parameter int WIDE_W   = 27,
   parameter int PRE_W    = 25,
   parameter bit PRE_ADD  = 1'b1,
   localparam int XW      = WIDE_W + 1,
   localparam int PROD_W  = 2 * WIDE_W + 1
) (
   input  logic                     mode_wide,
   input  logic [WIDE_W-1:0]        a,
   input  logic [WIDE_W-1:0]        d,
   input  logic [WIDE_W-1:0]        b,
   input  logic                     pre_en,
   input  logic                     pre_sub,
   output logic signed [PROD_W-1:0] prod
);

   logic signed [XW-1:0] a_x, d_x, b_x, pre;

   always_comb begin
      if (mode_wide) begin
         if (pre_en) a_x = {{(XW-PRE_W){a[PRE_W-1]}}, a[PRE_W-1:0]};
         else        a_x = {a[WIDE_W-1], a};
         d_x = {{(XW-PRE_W){d[PRE_W-1]}}, d[PRE_W-1:0]};
         b_x = {b[WIDE_W-1], b};
      end else begin
         a_x = {{(XW-NARROW_W){a[NARROW_W-1]}}, a[NARROW_W-1:0]};
         d_x = {{(XW-NARROW_W){d[NARROW_W-1]}}, d[NARROW_W-1:0]};
         b_x = {{(XW-NARROW_W){b[NARROW_W-1]}}, b[NARROW_W-1:0]};
      end
   end

   if (PRE_ADD) begin : g_preadd
      always_comb begin
         if (!pre_en)      pre = a_x;
         else if (pre_sub) pre = a_x - d_x;
         else              pre = a_x + d_x;
      end
   end else begin : g_no_preadd
      logic unused_pre;
      assign unused_pre = pre_sub ^ (|d_x);
      assign pre = a_x;
   end

   assign prod = pre * b_x;

endmodule

// File: rtl/vp_accum_out.sv
module vp_accum_out import vp_mac_pkg::*; #(
   parameter int ACC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [ACC_W-1:0] in_sum,
   input  logic             acc_en,
   input  logic             acc_clr,
   input  logic             osel,
   output logic [ACC_W-1:0] out_res,
   output logic             out_vld,
   output logic [ACC_W-1:0] out_acc
);

   logic [ACC_W-1:0] acc_q, res_q, feedback, acc_nxt;
   logic             vld_q;

   assign feedback = (acc_en && !acc_clr) ? acc_q : '0;
   assign acc_nxt  = feedback + in_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) begin
            acc_q <= acc_nxt;
            res_q <= (osel == OSEL_SUM) ? in_sum : acc_nxt;
         end
      end
   end

   assign out_res = res_q;
   assign out_vld = vld_q;
   assign out_acc = acc_q;

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(res_q) && $stable(acc_q)); // R9
   AST_NO_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !acc_en) |=> acc_q == $past(in_sum)); // R7
   AST_CLEAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && acc_clr) |=> acc_q == $past(in_sum)); // R8
   AST_SUM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && osel == OSEL_SUM) |=> res_q == $past(in_sum)); // R10

endmodule

// File: rtl/vp_mac_slice.sv
module vp_mac_slice import vp_mac_pkg::*; #(
   parameter int NARROW_W   = 18,
   parameter int WIDE_W     = 27,
   parameter int PRE_W      = 25,
   parameter int ACC_W      = 64,
   parameter int COEF_DEPTH = 8,
   parameter bit PRE_ADD_EN = 1'b1,
   localparam int IDX_W     = $clog2(COEF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wide,
   input  logic              in_valid,
   input  logic [WIDE_W-1:0] a0,
   input  logic [WIDE_W-1:0] d0,
   input  logic [WIDE_W-1:0] b0,
   input  logic [WIDE_W-1:0] a1,
   input  logic [WIDE_W-1:0] d1,
   input  logic [WIDE_W-1:0] b1,
   input  logic [1:0]        pre_en,
   input  logic [1:0]        pre_sub,
   input  logic [1:0]        coef_sel,
   input  logic [IDX_W-1:0]  coef_idx0,
   input  logic [IDX_W-1:0]  coef_idx1,
   input  logic              sub_p1,
   input  logic              acc_en,
   input  logic              acc_clr,
   input  logic              out_sel,
   input  logic [ACC_W-1:0]  cascade_in,
   input  logic              coef_we,
   input  logic              coef_wsel,
   input  logic [IDX_W-1:0]  coef_waddr,
   input  logic [WIDE_W-1:0] coef_wdata,
   output logic [ACC_W-1:0]  result,
   output logic              result_valid,
   output logic [ACC_W-1:0]  cascade_out
);

   localparam int PROD_W = 2 * WIDE_W + 1;

   if (NARROW_W > PRE_W || PRE_W >= WIDE_W) begin : g_width_bad
      initial $fatal(1, "vp_mac_slice: need NARROW_W <= PRE_W < WIDE_W");
   end
   if (ACC_W < PROD_W + 1) begin : g_acc_bad
      initial $fatal(1, "vp_mac_slice: ACC_W too small for the wide product");
   end

   // gather per-path inputs
   logic [WIDE_W-1:0] a_in [NUM_PATHS];
   logic [WIDE_W-1:0] d_in [NUM_PATHS];
   logic [WIDE_W-1:0] b_in [NUM_PATHS];
   logic [IDX_W-1:0]  idx_in [NUM_PATHS];

   assign a_in[0] = a0;  assign a_in[1] = a1;
   assign d_in[0] = d0;  assign d_in[1] = d1;
   assign b_in[0] = b0;  assign b_in[1] = b1;
   assign idx_in[0] = coef_idx0;
   assign idx_in[1] = coef_idx1;

   // stage 1: input registers
   logic [WIDE_W-1:0] coef_rd [NUM_PATHS];
   logic [WIDE_W-1:0] s1_a [NUM_PATHS];
   logic [WIDE_W-1:0] s1_d [NUM_PATHS];
   logic [WIDE_W-1:0] s1_b [NUM_PATHS];
   logic [NUM_PATHS-1:0] s1_pre_en, s1_pre_sub;
   logic signed [PROD_W-1:0] prod [NUM_PATHS];

   logic             s1_vld, s1_mode, s1_sub, s1_acc_en, s1_clr, s1_osel;
   logic [ACC_W-1:0] s1_casc;

   for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
      vp_coef_bank #(
         .COEF_W (WIDE_W),
         .DEPTH  (COEF_DEPTH)
      ) i_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (coef_we && (coef_wsel == 1'(k))),
         .waddr (coef_waddr),
         .wdata (coef_wdata),
         .raddr (idx_in[k]),
         .rdata (coef_rd[k])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s1_a[k]       <= '0;
            s1_d[k]       <= '0;
            s1_b[k]       <= '0;
            s1_pre_en[k]  <= 1'b0;
            s1_pre_sub[k] <= 1'b0;
         end else begin
            s1_a[k]       <= a_in[k];
            s1_d[k]       <= d_in[k];
            s1_b[k]       <= coef_sel[k] ? coef_rd[k] : b_in[k];
            s1_pre_en[k]  <= pre_en[k];
            s1_pre_sub[k] <= pre_sub[k];
         end
      end

      vp_operand_path #(
         .NARROW_W (NARROW_W),
         .WIDE_W   (WIDE_W),
         .PRE_W    (PRE_W),
         .PRE_ADD  (PRE_ADD_EN)
      ) i_opath (
         .mode_wide (s1_mode),
         .a         (s1_a[k]),
         .d         (s1_d[k]),
         .b         (s1_b[k]),
         .pre_en    (s1_pre_en[k]),
         .pre_sub   (s1_pre_sub[k]),
         .prod      (prod[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld    <= 1'b0;
         s1_mode   <= MODE_DUAL;
         s1_sub    <= 1'b0;
         s1_acc_en <= 1'b0;
         s1_clr    <= 1'b0;
         s1_osel   <= OSEL_ACC;
         s1_casc   <= '0;
      end else begin
         s1_vld    <= in_valid;
         s1_mode   <= mode_wide;
         s1_sub    <= sub_p1;
         s1_acc_en <= acc_en;
         s1_clr    <= acc_clr;
         s1_osel   <= out_sel;
         s1_casc   <= cascade_in;
      end
   end

   // stage 2: product sum with cascade term
   logic [ACC_W-1:0] p0_x, p1_x, p1_term, sum_c;
   logic [ACC_W-1:0] s2_sum;
   logic             s2_vld, s2_acc_en, s2_clr, s2_osel;

   assign p0_x = {{(ACC_W-PROD_W){prod[0][PROD_W-1]}}, prod[0]};
   assign p1_x = {{(ACC_W-PROD_W){prod[1][PROD_W-1]}}, prod[1]};

   always_comb begin
      if (s1_mode == MODE_WIDE) p1_term = '0;
      else if (s1_sub)          p1_term = -p1_x;
      else                      p1_term = p1_x;
   end

   assign sum_c = p0_x + p1_term + s1_casc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_sum    <= '0;
         s2_vld    <= 1'b0;
         s2_acc_en <= 1'b0;
         s2_clr    <= 1'b0;
         s2_osel   <= OSEL_ACC;
      end else begin
         s2_sum    <= sum_c;
         s2_vld    <= s1_vld;
         s2_acc_en <= s1_acc_en;
         s2_clr    <= s1_clr;
         s2_osel   <= s1_osel;
      end
   end

   // stage 3: accumulator and output multiplexer
   vp_accum_out #(
      .ACC_W (ACC_W)
   ) i_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (s2_vld),
      .in_sum  (s2_sum),
      .acc_en  (s2_acc_en),
      .acc_clr (s2_clr),
      .osel    (s2_osel),
      .out_res (result),
      .out_vld (result_valid),
      .out_acc (cascade_out)
   );

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(in_valid, 3)); // R9

endmodule

// File: tb/test_vp_mac_slice.sv
module test_vp_mac_slice;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_wide, in_valid;
   logic [26:0] a0, d0, b0, a1, d1, b1;
   logic [1:0]  pre_en, pre_sub, coef_sel;
   logic [2:0]  coef_idx0, coef_idx1;
   logic        sub_p1, acc_en, acc_clr, out_sel;
   logic [63:0] cascade_in;
   logic        coef_we, coef_wsel;
   logic [2:0]  coef_waddr;
   logic [26:0] coef_wdata;
   logic [63:0] result, cascade_out;
   logic        result_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   vp_mac_slice i_vp_mac_slice (
      .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .in_valid(in_valid),
      .a0(a0), .d0(d0), .b0(b0), .a1(a1), .d1(d1), .b1(b1),
      .pre_en(pre_en), .pre_sub(pre_sub), .coef_sel(coef_sel),
      .coef_idx0(coef_idx0), .coef_idx1(coef_idx1), .sub_p1(sub_p1),
      .acc_en(acc_en), .acc_clr(acc_clr), .out_sel(out_sel),
      .cascade_in(cascade_in), .coef_we(coef_we), .coef_wsel(coef_wsel),
      .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
      .result(result), .result_valid(result_valid), .cascade_out(cascade_out)
   );

   typedef struct {
      logic        v;
      logic [63:0] res;
      logic [63:0] cas;
      string       tag;
   } exp_t;

   exp_t        exp_q [$];
   int          n_checks = 0;
   int          n_fail   = 0;
   logic [63:0] m_acc = '0;
   logic [63:0] m_res = '0;
   logic [26:0] m_coef [2][8];

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   function automatic logic [63:0] path_prod(logic wide, logic [26:0] a, logic [26:0] d,
                                             logic [26:0] b, logic pe, logic ps);
      longint av, dv, bv, pv;
      if (wide) begin
         bv = longint'($signed(b));
         if (pe) begin
            av = longint'($signed(a[24:0]));
            dv = longint'($signed(d[24:0]));
            pv = ps ? av - dv : av + dv;
         end else pv = longint'($signed(a));
      end else begin
         bv = longint'($signed(b[17:0]));
         if (pe) begin
            av = longint'($signed(a[17:0]));
            dv = longint'($signed(d[17:0]));
            pv = ps ? av - dv : av + dv;
         end else pv = longint'($signed(a[17:0]));
      end
      return 64'(pv * bv);
   endfunction

   task automatic set_idle();
      in_valid = 0; mode_wide = 0;
      a0 = '0; d0 = '0; b0 = '0; a1 = '0; d1 = '0; b1 = '0;
      pre_en = '0; pre_sub = '0; coef_sel = '0; coef_idx0 = '0; coef_idx1 = '0;
      sub_p1 = 0; acc_en = 0; acc_clr = 0; out_sel = 0; cascade_in = '0;
      coef_we = 0; coef_wsel = 0; coef_waddr = '0; coef_wdata = '0;
   endtask

   // one cycle: form this cycle's expectation, clock, compare the due entry
   task automatic step(string tag);
      logic [26:0] bb0, bb1;
      logic [63:0] p0, p1, sum;
      exp_t e;
      bb0 = coef_sel[0] ? m_coef[0][coef_idx0] : b0;
      bb1 = coef_sel[1] ? m_coef[1][coef_idx1] : b1;
      p0  = path_prod(mode_wide, a0, d0, bb0, pre_en[0], pre_sub[0]);
      p1  = mode_wide ? 64'd0 : path_prod(1'b0, a1, d1, bb1, pre_en[1], pre_sub[1]);
      if (!mode_wide && sub_p1) p1 = -p1;
      sum = p0 + p1 + cascade_in;
      if (in_valid) begin
         m_acc = ((acc_en && !acc_clr) ? m_acc : 64'd0) + sum;
         m_res = out_sel ? sum : m_acc;
      end
      e.v = in_valid; e.res = m_res; e.cas = m_acc; e.tag = tag;
      exp_q.push_back(e);
      if (coef_we) m_coef[coef_wsel][coef_waddr] = coef_wdata;
      @(posedge clk);
      @(negedge clk);
      if (exp_q.size() >= 3) begin
         e = exp_q.pop_front();
         chk(e.tag, "valid", {63'd0, result_valid}, {63'd0, e.v});
         chk(e.tag, "result", result, e.res);
         chk(e.tag, "cascade_out", cascade_out, e.cas);
      end
   endtask

   task automatic flush(string tag);
      set_idle();
      a0 = 27'h5A5A5A; b1 = 27'h123; cascade_in = 64'hDEAD;  // ignored: no valid
      repeat (3) step(tag);
      set_idle();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      exp_t r;
      for (int i = 0; i < 2; i++) for (int j = 0; j < 8; j++) m_coef[i][j] = '0;
      set_idle();
      rst_n = 0;
      in_valid = 1;  // ignored while in reset
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R11", "reset result", result, 64'd0);
      chk("R11", "reset cascade_out", cascade_out, 64'd0);
      chk("R11", "reset valid", {63'd0, result_valid}, 64'd0);
      set_idle();
      rst_n = 1;
      r.v = 0; r.res = '0; r.cas = '0; r.tag = "R11";
      exp_q.push_back(r);
      exp_q.push_back(r);

      // R1: two narrow products summed, add and subtract
      a0 = 27'd1234; b0 = 27'h3FFF0; a1 = 27'h3FF00; b1 = 27'd777; in_valid = 1;
      step("R1");
      a0 = 27'h20000; b0 = 27'h20000; a1 = 27'h1FFFF; b1 = 27'h1FFFF; sub_p1 = 1;
      step("R1");
      a0 = 27'h7FF_FFFF; b0 = 27'd3; a1 = 27'd100; b1 = 27'd200; sub_p1 = 0;
      step("R1");
      flush("R1");

      // R2: 9-bit operands sign-extended into 18 bits
      in_valid = 1;
      a0 = 27'h3FF00; b0 = 27'h3FF00; a1 = 27'd255; b1 = 27'h3FF01;
      step("R2");
      a0 = 27'd255; b0 = 27'd255; a1 = 27'h3FFFF; b1 = 27'd1; sub_p1 = 1;
      step("R2");
      flush("R2");

      // R3: single wide product, path 1 ignored
      mode_wide = 1; in_valid = 1;
      a0 = 27'h400_0000; b0 = 27'h400_0000; a1 = 27'h12345; b1 = 27'h54321; sub_p1 = 1;
      step("R3");
      a0 = 27'h3FF_FFFF; b0 = 27'h400_0001; a1 = 27'h7FF_FFFF; b1 = 27'h7FF_FFFF;
      step("R3");
      flush("R3");

      // R4: pre-adder in both modes
      in_valid = 1; pre_en = 2'b11;
      a0 = 27'h1FFFF; d0 = 27'h1FFFF; b0 = 27'd5; a1 = 27'h20000; d1 = 27'd1; b1 = 27'd7;
      pre_sub = 2'b10;
      step("R4");
      mode_wide = 1; pre_en = 2'b01; pre_sub = 2'b00;
      a0 = 27'h0FF_FFFF; d0 = 27'h0FF_FFFF; b0 = 27'h3FF_FFFF;
      step("R4");
      a0 = 27'h100_0000; d0 = 27'h0FF_FFFF; pre_sub = 2'b01; b0 = 27'h400_0000;
      step("R4");
      mode_wide = 1; pre_en = 2'b00; a0 = 27'h7FF_FFF1; d0 = 27'h7FF_FFFF; b0 = 27'd9;
      step("R4");
      flush("R4");

      // R5: coefficient banks, write visible on the next cycle
      coef_we = 1; coef_wsel = 0; coef_waddr = 3'd3; coef_wdata = 27'h7FF_FFFE;
      in_valid = 1; a0 = 27'd11; coef_sel = 2'b01; coef_idx0 = 3'd3;
      step("R5");
      coef_wsel = 1; coef_waddr = 3'd6; coef_wdata = 27'h1_2345;
      step("R5");
      coef_we = 0; a1 = 27'd3; coef_sel = 2'b11; coef_idx1 = 3'd6; b0 = 27'd99; b1 = 27'd99;
      step("R5");
      mode_wide = 1; coef_sel = 2'b01; a0 = 27'h200_0000;
      step("R5");
      flush("R5");

      // R6: cascade input added, cascade output carries the accumulator
      in_valid = 1; a0 = 27'd10; b0 = 27'd10; cascade_in = 64'h0000_0100_0000_0000;
      step("R6");
      cascade_in = 64'hFFFF_FFFF_FFFF_FF00;
      step("R6");
      flush("R6");

      // R7: accumulate with wrap-around
      in_valid = 1; acc_en = 1; acc_clr = 1; cascade_in = 64'h7FFF_FFFF_FFFF_FFF0;
      step("R7");
      acc_clr = 0;
      step("R7");
      a0 = 27'd2; b0 = 27'h3FFFF;
      step("R7");
      acc_en = 0; cascade_in = '0; a0 = 27'd6; b0 = 27'd7;
      step("R7");
      flush("R7");

      // R8: clear reloads mid-run
      in_valid = 1; acc_en = 1; a0 = 27'd100; b0 = 27'd3;
      step("R8");
      step("R8");
      acc_clr = 1; a0 = 27'd4; b0 = 27'd4;
      step("R8");
      acc_clr = 0;
      step("R8");
      flush("R8");

      // R9: gaps between samples hold the outputs
      in_valid = 1; a0 = 27'd77; b0 = 27'd3;
      step("R9");
      in_valid = 0; a0 = 27'd5000; b0 = 27'd5000; cascade_in = 64'd9;
      step("R9");
      step("R9");
      in_valid = 1; acc_en = 1; a0 = 27'd1; b0 = 27'd1; cascade_in = '0;
      step("R9");
      flush("R9");

      // R10: output multiplexer selects sum while accumulating
      in_valid = 1; acc_en = 1; acc_clr = 1; a0 = 27'd50; b0 = 27'd2;
      step("R10");
      acc_clr = 0; out_sel = 1; cascade_in = 64'd1;
      step("R10");
      out_sel = 0; cascade_in = '0;
      step("R10");
      flush("R10");

      finish_run();
   end

endmodule